// File: doc/BRIEF.md
# I2C Controller Interrupt and Soft-Reset Unit

This unit sits between the protocol engine of an I2C controller and a simple 32-bit register bus. The engine reports eight event conditions on input wires. The unit latches each of them into a sticky status register. An enable register selects which latched events may raise the single interrupt line. A global enable bit then gates that line as a whole. Software acknowledges an event by writing a one to its status bit. Some sources are live levels, which a level-sensitive input keeps re-asserting for as long as the condition lasts. The others are one-shot events, which are caught on their rising edge.

The same register space holds a soft-reset register. Writing a specific key value to it clears the interrupt registers. The write also drives a reset pulse of fixed length into the controller core. Any other value written there is ignored.

Top module: `i2c_irq_unit`

## Requirements
- R1: Status bit n follows event input n. The bit order from bit 0 is: arbitration lost, transmit error/complete, transmit FIFO empty, receive FIFO at threshold, bus not busy, addressed as slave, not addressed as slave, transmit FIFO half empty. A raised event is readable in the status register after the next rising clock edge.
- R2: Edge-type sources (bits 0, 1, 5 and 6 by default) set their status bit only on a low-to-high change of the input. An input that stays high does not set the bit again after it has been cleared.
- R3: Level-type sources (bits 2, 3, 4 and 7 by default) set their status bit on every cycle the input is high. During the cycle that follows a clear, the bit reads 0. If the condition still holds, the bit reads 1 again one cycle later.
- R4: A write to the status register (offset 0x20) clears each bit written as 1 and leaves each bit written as 0 unchanged. A clear takes priority over a set in the same cycle.
- R5: Status bits latch regardless of the enable register.
- R6: `irq_o` is high exactly when the global enable bit is set and at least one bit of (status AND enable) is 1.
- R7: The global enable register sits at offset 0x1C and keeps only bit 31; its other bits read as 0. The enable register sits at offset 0x28 and keeps its low eight bits; the upper bits read as 0. Unmapped offsets read as 0.
- R8: Writing exactly 0x0000000A to offset 0x40 clears status, enable and global enable at that edge. It also drives `core_rst_o` high for 16 consecutive cycles, starting right after that edge. A key write is accepted only while no pulse is running.
- R9: Writing any other value to offset 0x40 changes no register and raises no reset. Reads of offset 0x40 return 0.
- R10: After `rst_n` is released, all three registers read 0, and `irq_o` and `core_rst_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte offset of the accessed register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| evt_i | input | 8 | Event conditions from the protocol engine |
| irq_o | output | 1 | Interrupt request |
| core_rst_o | output | 1 | Reset pulse to the controller core |

## Verification
Every register in the unit updates on the rising edge that samples the write or the event. Read data, `irq_o` and `core_rst_o` follow from those registers without any further stage, so each result is due one edge after its stimulus. The bench drives inputs on falling edges and samples a few nanoseconds after the next rising edge. The level re-set case is checked in two samples: one right after the clearing edge, where the bit must read 0, and one after the following edge, where it must read 1. The reset pulse is measured by counting falling edges while `core_rst_o` is high.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

   // register byte offsets within the block
   localparam int unsigned OFS_GIE  = 32'h1C;
   localparam int unsigned OFS_STS  = 32'h20;
   localparam int unsigned OFS_IER  = 32'h28;
   localparam int unsigned OFS_SRST = 32'h40;

   // value that triggers the soft reset
   localparam logic [31:0] SRST_KEY = 32'h0000_000A;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_GIE,
      SEL_STS,
      SEL_IER,
      SEL_SRST
   } reg_sel_e;

endpackage

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
   parameter int unsigned      N_SRC      = 8,
   parameter logic [N_SRC-1:0] LEVEL_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic [N_SRC-1:0] src_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] sts_o
);

   if (N_SRC < 1) begin : g_bad_n
      $error("i2c_irq_status: N_SRC must be at least 1");
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_bit
      logic set_w;

      if (LEVEL_MASK[i]) begin : g_level
         assign set_w = src_i[i];

         // R3
         level_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src_i[i] && !clr_i[i] && !flush_i) |=> sts_o[i]);
      end else begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= src_i[i];
         end
         assign set_w = src_i[i] & ~prev_q;

         // R2
         edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !src_i[i] |=> !$rose(sts_o[i]));
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         sts_o[i] <= 1'b0;
         else if (flush_i)   sts_o[i] <= 1'b0;
         else if (clr_i[i])  sts_o[i] <= 1'b0;
         else if (set_w)     sts_o[i] <= 1'b1;
      end

      // R4
      clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clr_i[i] |=> !sts_o[i]);
   end

endmodule

// File: rtl/i2c_irq_softrst.sv
module i2c_irq_softrst #(
   parameter int unsigned      DW         = 32,
   parameter int unsigned      RST_CYCLES = 16,
   parameter logic [DW-1:0]    KEY        = DW'(32'hA)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [DW-1:0] wdata_i,
   output logic          accept_o,
   output logic          core_rst_o
);

   localparam int unsigned CW = $clog2(RST_CYCLES + 1);

   if (RST_CYCLES < 1) begin : g_bad_len
      $error("i2c_irq_softrst: RST_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   assign core_rst_o = (cnt_q != '0);
   assign accept_o   = wr_i && (wdata_i == KEY) && !core_rst_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (accept_o)   cnt_q <= CW'(RST_CYCLES);
      else if (core_rst_o) cnt_q <= cnt_q - 1'b1;
   end

   // checker: length of each reset pulse
   logic [CW:0] run_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_len_q <= '0;
      else if (core_rst_o) run_len_q <= run_len_q + 1'b1;
      else                 run_len_q <= '0;
   end

   // R8
   pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_rst_o) |-> (run_len_q == (CW+1)'(RST_CYCLES)));

   // R8
   pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> core_rst_o);

   // R9
   bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && wdata_i != KEY && !core_rst_o) |=> !core_rst_o);

endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
   import i2c_irq_pkg::*;
#(
   parameter int unsigned         NUM_SRC    = 8,
   parameter logic [NUM_SRC-1:0]  LEVEL_MASK = 8'h9C,
   parameter int unsigned         RST_CYCLES = 16,
   parameter int unsigned         AW         = 8,
   parameter int unsigned         DW         = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr_i,
   input  logic [AW-1:0]      bus_addr_i,
   input  logic [DW-1:0]      bus_wdata_i,
   output logic [DW-1:0]      bus_rdata_o,
   input  logic [NUM_SRC-1:0] evt_i,
   output logic               irq_o,
   output logic               core_rst_o
);

   localparam int unsigned GIE_BIT = DW - 1;

   if (NUM_SRC < 1 || NUM_SRC > DW - 1) begin : g_bad_src
      $error("i2c_irq_unit: NUM_SRC must lie in 1..DW-1");
   end
   if (AW < 7) begin : g_bad_aw
      $error("i2c_irq_unit: AW too narrow for the register map");
   end
   if (DW < 32) begin : g_bad_dw
      $error("i2c_irq_unit: DW must be at least 32");
   end

   reg_sel_e sel;
   always_comb begin
      if      (bus_addr_i == AW'(OFS_GIE))  sel = SEL_GIE;
      else if (bus_addr_i == AW'(OFS_STS))  sel = SEL_STS;
      else if (bus_addr_i == AW'(OFS_IER))  sel = SEL_IER;
      else if (bus_addr_i == AW'(OFS_SRST)) sel = SEL_SRST;
      else                                  sel = SEL_NONE;
   end

   logic wr_gie, wr_sts, wr_ier, wr_srst;
   assign wr_gie  = bus_wr_i && (sel == SEL_GIE);
   assign wr_sts  = bus_wr_i && (sel == SEL_STS);
   assign wr_ier  = bus_wr_i && (sel == SEL_IER);
   assign wr_srst = bus_wr_i && (sel == SEL_SRST);

   logic               srst_accept;
   logic [NUM_SRC-1:0] sts;
   logic [NUM_SRC-1:0] sts_clr;
   logic [NUM_SRC-1:0] ier_q;
   logic               gie_q;

   assign sts_clr = wr_sts ? bus_wdata_i[NUM_SRC-1:0] : '0;

   i2c_irq_status #(
      .N_SRC      (NUM_SRC),
      .LEVEL_MASK (LEVEL_MASK)
   ) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (srst_accept),
      .src_i   (evt_i),
      .clr_i   (sts_clr),
      .sts_o   (sts)
   );

   i2c_irq_softrst #(
      .DW         (DW),
      .RST_CYCLES (RST_CYCLES),
      .KEY        (DW'(SRST_KEY))
   ) u_softrst (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (wr_srst),
      .wdata_i    (bus_wdata_i),
      .accept_o   (srst_accept),
      .core_rst_o (core_rst_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ier_q <= '0;
      else if (srst_accept) ier_q <= '0;
      else if (wr_ier)      ier_q <= bus_wdata_i[NUM_SRC-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           gie_q <= 1'b0;
      else if (srst_accept) gie_q <= 1'b0;
      else if (wr_gie)      gie_q <= bus_wdata_i[GIE_BIT];
   end

   always_comb begin
      bus_rdata_o = '0;
      unique case (sel)
         SEL_GIE: bus_rdata_o[GIE_BIT]     = gie_q;
         SEL_STS: bus_rdata_o[NUM_SRC-1:0] = sts;
         SEL_IER: bus_rdata_o[NUM_SRC-1:0] = ier_q;
         default: bus_rdata_o = '0;
      endcase
   end

   assign irq_o = gie_q & (|(sts & ier_q));

   // R6
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_q |-> !irq_o);

   // R6
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts == '0) |-> !irq_o);

   // R8
   srst_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst_accept |=> (sts == '0 && ier_q == '0 && !gie_q));

   // R9
   srst_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_srst && !srst_accept) |=> ($stable(ier_q) && $stable(gie_q)));

   // R9
   srst_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_SRST) |-> (bus_rdata_o == '0));

endmodule

// File: tb/tb_i2c_irq_unit.sv
`timescale 1ns/1ps
module tb_i2c_irq_unit;

   localparam logic [7:0] A_GIE  = 8'h1C;
   localparam logic [7:0] A_STS  = 8'h20;
   localparam logic [7:0] A_IER  = 8'h28;
   localparam logic [7:0] A_SRST = 8'h40;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_wr_i;
   logic [7:0]  bus_addr_i;
   logic [31:0] bus_wdata_i;
   logic [31:0] bus_rdata_o;
   logic [7:0]  evt_i;
   logic        irq_o;
   logic        core_rst_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   i2c_irq_unit dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr_i    (bus_wr_i),
      .bus_addr_i  (bus_addr_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .evt_i       (evt_i),
      .irq_o       (irq_o),
      .core_rst_o  (core_rst_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
      @(negedge clk);
      bus_wr_i = 1'b0; bus_wdata_i = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr_i = a;
      #2 v = bus_rdata_o;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_STS, v);  chk("R10 status", v, 0);
      rd(A_IER, v);  chk("R10 enable", v, 0);
      rd(A_GIE, v);  chk("R10 global", v, 0);
      chk("R10 irq", irq_o, 0);
      chk("R10 core_rst", core_rst_o, 0);
   endtask

   task automatic t_level();
      logic [31:0] v;
      @(negedge clk); evt_i = 8'h04;
      rd(A_STS, v);  chk("R1 tx-empty bit2", v, 32'h04);
      @(negedge clk);
      bus_wr_i = 1'b1; bus_addr_i = A_STS; bus_wdata_i = 32'h04;
      @(posedge clk); #2 chk("R3 cleared cycle", bus_rdata_o, 0);
      @(negedge clk); bus_wr_i = 1'b0; bus_wdata_i = '0;
      @(posedge clk); #2 chk("R3 level re-set", bus_rdata_o, 32'h04);
      @(negedge clk); evt_i = 8'h00;
      wr(A_STS, 32'h04);
      rd(A_STS, v);  chk("R4 level cleared", v, 0);
      @(negedge clk); evt_i = 8'h80;
      rd(A_STS, v);  chk("R1 half-empty bit7", v, 32'h80);
      @(negedge clk); evt_i = 8'h00;
      wr(A_STS, 32'h80);
   endtask

   task automatic t_pulse();
      logic [31:0] v;
      @(negedge clk); evt_i = 8'h01;
      rd(A_STS, v);  chk("R1 arb-lost bit0", v, 32'h01);
      wr(A_STS, 32'h01);
      rd(A_STS, v);  chk("R2 held no re-set", v, 0);
      rd(A_STS, v);  chk("R2 held no re-set later", v, 0);
      @(negedge clk); evt_i = 8'h00;
      @(negedge clk); evt_i = 8'h01;
      rd(A_STS, v);  chk("R2 new rising edge", v, 32'h01);
      @(negedge clk); evt_i = 8'h00;
      wr(A_STS, 32'h01);
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      @(negedge clk); evt_i = 8'h21;
      @(negedge clk); evt_i = 8'h00;
      rd(A_STS, v);  chk("R1 bits 0 and 5", v, 32'h21);
      wr(A_STS, 32'h01);
      rd(A_STS, v);  chk("R4 clear bit0 only", v, 32'h20);
      wr(A_STS, 32'h00);
      rd(A_STS, v);  chk("R4 zero write keeps", v, 32'h20);
      wr(A_STS, 32'h20);
      rd(A_STS, v);  chk("R4 clear bit5", v, 0);
   endtask

   task automatic t_mask();
      logic [31:0] v;
      @(negedge clk); evt_i = 8'h02;
      @(negedge clk); evt_i = 8'h00;
      rd(A_STS, v);  chk("R5 latched while disabled", v, 32'h02);
      chk("R6 no irq ier=0", irq_o, 0);
      wr(A_GIE, 32'hFFFF_FFFF);
      rd(A_GIE, v);  chk("R7 global only bit31", v, 32'h8000_0000);
      chk("R6 no irq gie only", irq_o, 0);
      wr(A_IER, 32'hFFFF_FFFF);
      rd(A_IER, v);  chk("R7 enable low byte", v, 32'h0000_00FF);
      chk("R6 irq asserted", irq_o, 1);
      wr(A_GIE, 32'h0);
      #1 chk("R6 gie off", irq_o, 0);
      wr(A_GIE, 32'h8000_0000);
      #1 chk("R6 gie on", irq_o, 1);
      wr(A_STS, 32'h02);
      #1 chk("R6 cleared status", irq_o, 0);
      rd(8'h30, v);  chk("R7 unmapped read", v, 0);
   endtask

   task automatic t_srst();
      logic [31:0] v;
      int n;
      @(negedge clk); evt_i = 8'h10;
      @(negedge clk); evt_i = 8'h00;
      #1 chk("R6 irq before reset", irq_o, 1);
      wr(A_SRST, 32'h5);
      #1 chk("R9 bad key no pulse", core_rst_o, 0);
      rd(A_IER, v);  chk("R9 enable kept", v, 32'hFF);
      rd(A_STS, v);  chk("R9 status kept", v, 32'h10);
      rd(A_SRST, v); chk("R9 reads zero", v, 0);
      wr(A_SRST, 32'hA);
      n = 0;
      while (core_rst_o && n < 100) begin
         n++;
         @(negedge clk);
      end
      chk("R8 pulse length", n, 16);
      rd(A_STS, v);  chk("R8 status flushed", v, 0);
      rd(A_IER, v);  chk("R8 enable flushed", v, 0);
      rd(A_GIE, v);  chk("R8 global flushed", v, 0);
      chk("R8 irq low", irq_o, 0);
   endtask

   initial begin
      rst_n = 1'b0; bus_wr_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0; evt_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_level();
      t_pulse();
      t_w1c();
      t_mask();
      t_srst();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule